// File: doc/BRIEF.md
# Parallel NOR Flash Command Decoder Model

A synthesizable device-side model of a small parallel NOR flash array. It sits on a synchronous word bus with address, write data, write strobe, read strobe and read data. It reads as ordinary memory until the host writes a two-step unlock prefix followed by a command byte. It then carries out the command with the same visible behaviour as a real part: an identification mode that answers fixed codes at fixed offsets, single-word programming, sector erase with an acceptance window before the erase itself, and buffered programming of up to `BUF_WORDS` words.

While an internal operation runs, every read returns a polling status word in place of array data. The host can poll that word the same way it would poll a real device. Program and erase times are counted in clock cycles. When the count ends, the model goes back to array reads without any action from the host. A command byte is the low byte of the write data. The array is `2**SECT_AW` words per sector times `NUM_SECT` sectors, and it holds all ones at power-up.

Top module: `nor_cmd_model`

## Requirements
- R1: A command is accepted only after writes of 0xAA to address 0x555 and then 0x55 to address 0x2AA. Any other write in the second step sends the model back to array reads, and the command that follows is not taken.
- R2: After the prefix, 0x90 written at 0x555 enters identification mode. Reads there return `ID_VENDOR` (0x0001) at address 0, `ID_DEVICE` (0x227E) at address 1, `ID_EXT1` (0x2210) at 0x00E and `ID_EXT2` (0x2201) at 0x00F. Offset 2 of any sector reads 0 (unlocked), and every other address also reads 0.
- R3: 0xF0 written at any address while in array-read, prefix or identification mode returns the model to array reads. Identification mode ignores every other write.
- R4: Array words read 0xFFFF at power-up. A sector erase sets every word of the chosen sector to 0xFFFF and leaves other sectors unchanged.
- R5: The prefix, then 0xA0 at 0x555, then a data write programs that address. The stored word becomes the old word ANDed with the new data.
- R6: While busy, a read at any address returns a status word. Bit 7 is the complement of bit 7 of the expected data: the last data word written, or 1 for erase. Bit 6 reads 0 on the first status read and inverts on each further read. Bit 3 carries the erase phase. All other bits are 0.
- R7: The erase sequence is the prefix, 0x80 at 0x555, the prefix again, then 0x30 at any address in the target sector. For `WIN_CYC` cycles status bit 3 reads 0 (acceptance window). After that it reads 1 while the erase runs.
- R8: Buffered programming is the prefix, 0x25 at a sector address, a count N-1, N data writes inside that sector, then 0x29. After the commit, each of the N words becomes old AND new.
- R9: The buffer sequence is abandoned with nothing programmed in three cases: the count exceeds `BUF_WORDS`-1, a data write falls outside the sector, or the final write is not 0x29.
- R10: Programming is busy for max(`PROG_CYC`, N+1) cycles and erase for `WIN_CYC` + max(`ERS_CYC`, sector words) cycles, counted from the edge that takes the last command write. Array reads then resume without any action from the host. Writes during busy are ignored.
- R11: Read data is valid in the cycle after the read strobe. A synchronous active-high reset returns the model to array reads, ends any operation in progress, and keeps the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data; the low byte carries commands |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | DW | Read data, valid the cycle after `bus_re` |

## Verification
The hardest situation to reach from the ports is the exact last cycle of each busy phase. This covers the final cycle of the erase acceptance window, the last status read of a program or erase, and the first array read after it. The bench counts clock edges from the edge that takes the final command write and places reads on both sides of each boundary. It checks the status bits and the toggle sequence there, and the returned array word one read later. A reset landing in the first busy cycle is also driven, so that the interrupted program leaves the array word untouched.

// File: rtl/nor_pkg.sv
package nor_pkg;

  typedef enum logic [3:0] {
    M_READ, M_UNL1, M_UNL2, M_ID,
    M_ERS_PRE, M_ERS_U1, M_ERS_U2,
    M_PROG, M_BCNT, M_BDATA, M_BCMT,
    M_PGM, M_EWIN, M_ERUN
  } nor_mode_e;

  localparam logic [7:0] OP_KEY1      = 8'hAA;
  localparam logic [7:0] OP_KEY2      = 8'h55;
  localparam logic [7:0] OP_IDENT     = 8'h90;
  localparam logic [7:0] OP_EXIT      = 8'hF0;
  localparam logic [7:0] OP_WORD      = 8'hA0;
  localparam logic [7:0] OP_ERS_ARM   = 8'h80;
  localparam logic [7:0] OP_ERS_GO    = 8'h30;
  localparam logic [7:0] OP_BUF_OPEN  = 8'h25;
  localparam logic [7:0] OP_BUF_SHUT  = 8'h29;

  localparam int unsigned KEY_ADDR1 = 'h555;
  localparam int unsigned KEY_ADDR2 = 'h2AA;

endpackage

// File: rtl/nor_array.sv
module nor_array #(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          ren,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rq,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // blank device: every cell starts erased
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we)  mem[waddr] <= wdata;
    if (ren) rq <= mem[raddr];
  end
endmodule

// File: rtl/nor_ctrl.sv
module nor_ctrl
  import nor_pkg::*;
#(
  parameter int AW        = 11,
  parameter int DW        = 16,
  parameter int SECT_AW   = 9,
  parameter int BUF_WORDS = 8,
  parameter int PROG_CYC  = 20,
  parameter int WIN_CYC   = 10,
  parameter int ERS_CYC   = 600
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] arr_q,
  output nor_mode_e     mode,
  output logic          busy,
  output logic          ers_run,
  output logic          exp_msb,
  output logic          ar_en,
  output logic [AW-1:0] ar_addr,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata
);
  localparam int SW         = AW - SECT_AW;
  localparam int SECT_WORDS = 1 << SECT_AW;
  localparam int BI         = $clog2(BUF_WORDS);
  localparam int NW         = BI + 1;
  localparam int ERS_LEN    = (ERS_CYC > SECT_WORDS) ? ERS_CYC : SECT_WORDS;
  localparam int PGM_MAX    = (PROG_CYC > BUF_WORDS + 1) ? PROG_CYC : BUF_WORDS + 1;
  localparam int LEN_A      = (ERS_LEN > PGM_MAX) ? ERS_LEN : PGM_MAX;
  localparam int MAXLEN     = (LEN_A > WIN_CYC) ? LEN_A : WIN_CYC;
  localparam int CW         = $clog2(MAXLEN + 1);
  localparam logic [AW-1:0] ADR1 = AW'(KEY_ADDR1);
  localparam logic [AW-1:0] ADR2 = AW'(KEY_ADDR2);

  logic [CW-1:0] cnt;
  logic [SW-1:0] sect;
  logic [NW-1:0] nwords, fill;
  logic [AW-1:0] buf_a [BUF_WORDS];
  logic [DW-1:0] buf_d [BUF_WORDS];

  logic          at1, at2;
  logic [7:0]    op;
  logic [SW-1:0] a_sect;
  logic [BI-1:0] rd_i, wr_i, last_i, fill_i;
  logic [NW-1:0] fill_nx;

  assign at1     = (addr == ADR1);
  assign at2     = (addr == ADR2);
  assign op      = wdata[7:0];
  assign a_sect  = addr[AW-1:SECT_AW];
  assign rd_i    = cnt[BI-1:0];
  assign wr_i    = BI'(cnt - 1'b1);
  assign last_i  = BI'(nwords - 1'b1);
  assign fill_i  = fill[BI-1:0];
  assign fill_nx = fill + 1'b1;

  // command sequencer and busy timer
  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= M_READ;
      cnt    <= '0;
      sect   <= '0;
      nwords <= '0;
      fill   <= '0;
    end else begin
      case (mode)
        M_READ:    if (we && at1 && op == OP_KEY1) mode <= M_UNL1;
        M_UNL1:    if (we) mode <= (at2 && op == OP_KEY2) ? M_UNL2 : M_READ;
        M_UNL2: if (we) begin
          mode <= M_READ;
          if (at1 && op == OP_IDENT)        mode <= M_ID;
          else if (at1 && op == OP_WORD)    mode <= M_PROG;
          else if (at1 && op == OP_ERS_ARM) mode <= M_ERS_PRE;
          else if (op == OP_BUF_OPEN) begin
            mode <= M_BCNT;
            sect <= a_sect;
          end
        end
        M_ID:      if (we && op == OP_EXIT) mode <= M_READ;
        M_ERS_PRE: if (we) mode <= (at1 && op == OP_KEY1) ? M_ERS_U1 : M_READ;
        M_ERS_U1:  if (we) mode <= (at2 && op == OP_KEY2) ? M_ERS_U2 : M_READ;
        M_ERS_U2: if (we) begin
          if (op == OP_ERS_GO) begin
            mode <= M_EWIN;
            sect <= a_sect;
            cnt  <= '0;
          end else mode <= M_READ;
        end
        M_PROG: if (we) begin
          nwords <= NW'(1);
          cnt    <= '0;
          mode   <= M_PGM;
        end
        M_BCNT: if (we) begin
          if (wdata < DW'(BUF_WORDS)) begin
            nwords <= NW'(wdata[BI-1:0]) + NW'(1);
            fill   <= '0;
            mode   <= M_BDATA;
          end else mode <= M_READ;
        end
        M_BDATA: if (we) begin
          if (a_sect != sect) mode <= M_READ;
          else begin
            fill <= fill_nx;
            if (fill_nx == nwords) mode <= M_BCMT;
          end
        end
        M_BCMT: if (we) begin
          if (op == OP_BUF_SHUT) begin
            cnt  <= '0;
            mode <= M_PGM;
          end else mode <= M_READ;
        end
        M_PGM: begin
          cnt <= cnt + 1'b1;
          if (cnt >= CW'(nwords) && cnt >= CW'(PROG_CYC - 1)) mode <= M_READ;
        end
        M_EWIN: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(WIN_CYC - 1)) begin
            cnt  <= '0;
            mode <= M_ERUN;
          end
        end
        M_ERUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(ERS_LEN - 1)) mode <= M_READ;
        end
        default: mode <= M_READ;
      endcase
    end
  end

  // word collector shared by single-word and buffered programming
  always_ff @(posedge clk) begin
    if (mode == M_PROG && we) begin
      buf_a[0] <= addr;
      buf_d[0] <= wdata;
    end else if (mode == M_BDATA && we) begin
      buf_a[fill_i] <= addr;
      buf_d[fill_i] <= wdata;
    end
  end

  // array engine: pipelined read-then-AND for programming, sweep for erase
  always_comb begin
    busy      = (mode == M_PGM) || (mode == M_EWIN) || (mode == M_ERUN);
    ers_run   = (mode == M_ERUN);
    exp_msb   = (mode == M_PGM) ? buf_d[last_i][7] : 1'b1;
    ar_en     = re || (mode == M_PGM);
    ar_addr   = (mode == M_PGM) ? buf_a[rd_i] : addr;
    mem_we    = 1'b0;
    mem_waddr = buf_a[wr_i];
    mem_wdata = arr_q & buf_d[wr_i];
    if (mode == M_PGM)
      mem_we = (cnt != '0) && (cnt <= CW'(nwords));
    if (mode == M_ERUN) begin
      mem_we    = (cnt < CW'(SECT_WORDS));
      mem_waddr = {sect, cnt[SECT_AW-1:0]};
      mem_wdata = '1;
    end
  end
endmodule

// File: rtl/nor_cmd_model.sv
module nor_cmd_model
  import nor_pkg::*;
#(
  parameter int SECT_AW   = 9,
  parameter int NUM_SECT  = 4,
  parameter int DW        = 16,
  parameter int BUF_WORDS = 8,
  parameter int PROG_CYC  = 20,
  parameter int WIN_CYC   = 10,
  parameter int ERS_CYC   = 600,
  parameter int unsigned ID_VENDOR = 'h0001,
  parameter int unsigned ID_DEVICE = 'h227E,
  parameter int unsigned ID_EXT1   = 'h2210,
  parameter int unsigned ID_EXT2   = 'h2201,
  localparam int AW = SECT_AW + $clog2(NUM_SECT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  input  logic          bus_re,
  output logic [DW-1:0] bus_rdata
);
  nor_mode_e     mode;
  logic          busy, ers_run, exp_msb, ar_en, mem_we;
  logic [AW-1:0] ar_addr, mem_waddr;
  logic [DW-1:0] arr_q, mem_wdata;
  logic          sel_r, tog;
  logic [DW-1:0] hold_r, id_val, stat;

  nor_ctrl #(
    .AW(AW), .DW(DW), .SECT_AW(SECT_AW), .BUF_WORDS(BUF_WORDS),
    .PROG_CYC(PROG_CYC), .WIN_CYC(WIN_CYC), .ERS_CYC(ERS_CYC)
  ) u_ctrl (
    .clk(clk), .rst(rst), .we(bus_we), .re(bus_re), .addr(bus_addr),
    .wdata(bus_wdata), .arr_q(arr_q), .mode(mode), .busy(busy),
    .ers_run(ers_run), .exp_msb(exp_msb), .ar_en(ar_en), .ar_addr(ar_addr),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  nor_array #(.AW(AW), .DW(DW)) u_array (
    .clk(clk), .ren(ar_en), .raddr(ar_addr), .rq(arr_q),
    .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata)
  );

  // fixed identification answers; sector offset 2 (protection) falls to zero
  always_comb begin
    case (bus_addr)
      AW'(0):    id_val = DW'(ID_VENDOR);
      AW'(1):    id_val = DW'(ID_DEVICE);
      AW'('h0E): id_val = DW'(ID_EXT1);
      AW'('h0F): id_val = DW'(ID_EXT2);
      default:   id_val = '0;
    endcase
  end

  always_comb begin
    stat    = '0;
    stat[7] = ~exp_msb;
    stat[6] = tog;
    stat[3] = ers_run;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_r  <= 1'b0;
      hold_r <= '0;
      tog    <= 1'b0;
    end else begin
      if (!busy)       tog <= 1'b0;
      else if (bus_re) tog <= ~tog;
      if (bus_re) begin
        if (busy) begin
          sel_r  <= 1'b1;
          hold_r <= stat;
        end else if (mode == M_ID) begin
          sel_r  <= 1'b1;
          hold_r <= id_val;
        end else begin
          sel_r  <= 1'b0;
        end
      end
    end
  end

  assign bus_rdata = sel_r ? hold_r : arr_q;
endmodule

// File: rtl/nor_cmd_chk.sv
module nor_cmd_chk
  import nor_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          we,
  input logic          re,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input nor_mode_e     mode,
  input logic          busy,
  input logic          ers_run,
  input logic          mem_we,
  input logic [DW-1:0] mem_wdata,
  input logic [DW-1:0] arr_q
);
  localparam logic [AW-1:0] ADR1 = AW'(KEY_ADDR1);
  localparam logic [AW-1:0] ADR2 = AW'(KEY_ADDR2);
  localparam logic [DW-1:0] STAT_MASK = DW'('hC8);

  AST_PREFIX_ABORT: assert property (@(posedge clk) disable iff (rst)
    (mode == M_UNL1 && we && !(addr == ADR2 && wdata[7:0] == OP_KEY2)) |=> (mode == M_READ)); // R1

  AST_ID_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (mode == M_UNL2 && we && addr == ADR1 && wdata[7:0] == OP_IDENT) |=> (mode == M_ID)); // R2

  AST_EXIT_TO_READ: assert property (@(posedge clk) disable iff (rst)
    ((mode == M_READ || mode == M_UNL1 || mode == M_UNL2 || mode == M_ID)
     && we && wdata[7:0] == OP_EXIT) |=> (mode == M_READ)); // R3

  AST_ERASE_ONES: assert property (@(posedge clk) disable iff (rst)
    (mem_we && ers_run) |-> (&mem_wdata)); // R4

  AST_PROG_CLEAR_ONLY: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !ers_run) |-> ((mem_wdata & ~arr_q) == '0)); // R5

  AST_STATUS_BITS: assert property (@(posedge clk) disable iff (rst)
    (re && busy) |=> ((rdata & ~STAT_MASK) == '0)); // R6

  AST_ERASE_ORDER: assert property (@(posedge clk) disable iff (rst)
    $rose(ers_run) |-> ($past(mode) == M_EWIN)); // R7

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_we); // R10
endmodule

bind nor_cmd_model nor_cmd_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .we(bus_we), .re(bus_re), .addr(bus_addr),
  .wdata(bus_wdata), .rdata(bus_rdata), .mode(mode), .busy(busy),
  .ers_run(ers_run), .mem_we(mem_we), .mem_wdata(mem_wdata), .arr_q(arr_q)
);

// File: tb/sim_nor_cmd_model.sv
module sim_nor_cmd_model;
  logic        clk = 1'b0;
  logic        rst;
  logic [10:0] addr;
  logic [15:0] wdata;
  logic        we, re;
  logic [15:0] rdata;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  nor_cmd_model u0 (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_re(re), .bus_rdata(rdata)
  );

  typedef struct packed {
    logic [1:0]  op;   // 0 write, 1 read and compare, 2 idle d cycles
    logic [10:0] a;
    logic [15:0] d;
    logic [15:0] e;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 47;
  localparam vec_t TAB [NV] = '{
    // R2 identification answers
    '{2'd0, 11'h555, 16'h00AA, 16'h0, 4'd2},
    '{2'd0, 11'h2AA, 16'h0055, 16'h0, 4'd2},
    '{2'd0, 11'h555, 16'h0090, 16'h0, 4'd2},
    '{2'd1, 11'h000, 16'h0, 16'h0001, 4'd2},
    '{2'd1, 11'h001, 16'h0, 16'h227E, 4'd2},
    '{2'd1, 11'h00E, 16'h0, 16'h2210, 4'd2},
    '{2'd1, 11'h00F, 16'h0, 16'h2201, 4'd2},
    '{2'd1, 11'h202, 16'h0, 16'h0000, 4'd2},
    '{2'd1, 11'h200, 16'h0, 16'h0000, 4'd2},
    // R3 other writes ignored in identification mode, then exit
    '{2'd0, 11'h555, 16'h00AA, 16'h0, 4'd3},
    '{2'd1, 11'h000, 16'h0, 16'h0001, 4'd3},
    '{2'd0, 11'h000, 16'h00F0, 16'h0, 4'd3},
    '{2'd1, 11'h000, 16'h0, 16'hFFFF, 4'd3},
    // R5 program then AND-program
    '{2'd0, 11'h555, 16'h00AA, 16'h0, 4'd5},
    '{2'd0, 11'h2AA, 16'h0055, 16'h0, 4'd5},
    '{2'd0, 11'h555, 16'h00A0, 16'h0, 4'd5},
    '{2'd0, 11'h010, 16'h1234, 16'h0, 4'd5},
    '{2'd2, 11'h000, 16'd30,   16'h0, 4'd5},
    '{2'd1, 11'h010, 16'h0, 16'h1234, 4'd5},
    '{2'd0, 11'h555, 16'h00AA, 16'h0, 4'd5},
    '{2'd0, 11'h2AA, 16'h0055, 16'h0, 4'd5},
    '{2'd0, 11'h555, 16'h00A0, 16'h0, 4'd5},
    '{2'd0, 11'h010, 16'hFF0F, 16'h0, 4'd5},
    '{2'd2, 11'h000, 16'd30,   16'h0, 4'd5},
    '{2'd1, 11'h010, 16'h0, 16'h1204, 4'd5},
    // R1 wrong second-step address
    '{2'd0, 11'h555, 16'h00AA, 16'h0, 4'd1},
    '{2'd0, 11'h2AB, 16'h0055, 16'h0, 4'd1},
    '{2'd0, 11'h555, 16'h00A0, 16'h0, 4'd1},
    '{2'd0, 11'h020, 16'h0000, 16'h0, 4'd1},
    '{2'd2, 11'h000, 16'd30,   16'h0, 4'd1},
    '{2'd1, 11'h020, 16'h0, 16'hFFFF, 4'd1},
    // R1 wrong second-step data
    '{2'd0, 11'h555, 16'h00AA, 16'h0, 4'd1},
    '{2'd0, 11'h2AA, 16'h0054, 16'h0, 4'd1},
    '{2'd0, 11'h555, 16'h0090, 16'h0, 4'd1},
    '{2'd1, 11'h000, 16'h0, 16'hFFFF, 4'd1},
    // R3 exit from the prefix
    '{2'd0, 11'h555, 16'h00AA, 16'h0, 4'd3},
    '{2'd0, 11'h2AA, 16'h0055, 16'h0, 4'd3},
    '{2'd0, 11'h000, 16'h00F0, 16'h0, 4'd3},
    '{2'd0, 11'h555, 16'h00A0, 16'h0, 4'd3},
    '{2'd0, 11'h030, 16'h0000, 16'h0, 4'd3},
    '{2'd2, 11'h000, 16'd30,   16'h0, 4'd3},
    '{2'd1, 11'h030, 16'h0, 16'hFFFF, 4'd3},
    // R3 plain writes in array mode do nothing
    '{2'd0, 11'h031, 16'h0000, 16'h0, 4'd3},
    '{2'd0, 11'h2AA, 16'h0055, 16'h0, 4'd3},
    '{2'd0, 11'h555, 16'h00A0, 16'h0, 4'd3},
    '{2'd2, 11'h000, 16'd5,    16'h0, 4'd3},
    '{2'd1, 11'h031, 16'h0, 16'hFFFF, 4'd3}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [15:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [15:0] d);
    re = 1'b1; addr = a;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic unlock();
    wr(11'h555, 16'h00AA);
    wr(11'h2AA, 16'h0055);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    rst = 1'b1; we = 1'b0; re = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 reset state reads the blank array; R4 power-up content
    rd(11'h000, v); check("R11 reset read", v, 16'hFFFF);
    rd(11'h7FF, v); check("R4 blank top word", v, 16'hFFFF);

    for (int i = 0; i < NV; i++) begin
      case (TAB[i].op)
        2'd0: wr(TAB[i].a, TAB[i].d);
        2'd1: begin
          rd(TAB[i].a, v);
          check($sformatf("R%0d table entry %0d", TAB[i].rq, i), v, TAB[i].e);
        end
        default: idle(int'(TAB[i].d));
      endcase
    end

    // R6 status during program, R10 exact end of busy
    unlock(); wr(11'h555, 16'h00A0); wr(11'h040, 16'h5A3C);
    rd(11'h7FF, v); check("R6 status first read", v, 16'h0080);
    rd(11'h040, v); check("R6 status toggled", v, 16'h00C0);
    idle(17);
    rd(11'h040, v); check("R10 last busy cycle", v, 16'h0080);
    rd(11'h040, v); check("R10 first array read", v, 16'h5A3C);

    // R10 writes ignored while busy; R6 bit 7 for data with bit 7 set
    unlock(); wr(11'h555, 16'h00A0); wr(11'h050, 16'h00FF);
    rd(11'h050, v); check("R6 status msb data set", v, 16'h0000);
    wr(11'h050, 16'h0000); wr(11'h000, 16'h00F0);
    idle(30);
    rd(11'h050, v); check("R10 busy write ignored", v, 16'h00FF);

    // R7 erase window, R4 erase result, R10 erase length
    unlock(); wr(11'h555, 16'h00A0); wr(11'h210, 16'h0000);
    idle(30);
    rd(11'h210, v); check("R5 sector1 word cleared", v, 16'h0000);
    unlock(); wr(11'h555, 16'h0080); unlock(); wr(11'h200, 16'h0030);
    idle(9);
    rd(11'h210, v); check("R7 window bit3 low", v, 16'h0000);
    rd(11'h210, v); check("R7 erase bit3 high", v, 16'h0048);
    idle(598);
    rd(11'h210, v); check("R10 last erase cycle", v, 16'h0008);
    rd(11'h210, v); check("R4 erased word", v, 16'hFFFF);
    rd(11'h010, v); check("R4 other sector kept", v, 16'h1204);

    // R8 buffered program of three words, then AND through the buffer
    unlock(); wr(11'h300, 16'h0025); wr(11'h300, 16'h0002);
    wr(11'h300, 16'h1111); wr(11'h301, 16'h2222); wr(11'h302, 16'h3333);
    wr(11'h300, 16'h0029);
    rd(11'h300, v); check("R6 buffer status", v, 16'h0080);
    idle(40);
    rd(11'h300, v); check("R8 word 0", v, 16'h1111);
    rd(11'h301, v); check("R8 word 1", v, 16'h2222);
    rd(11'h302, v); check("R8 word 2", v, 16'h3333);
    unlock(); wr(11'h300, 16'h0025); wr(11'h300, 16'h0000);
    wr(11'h300, 16'h0F0F); wr(11'h300, 16'h0029);
    idle(40);
    rd(11'h300, v); check("R8 buffer AND", v, 16'h0101);

    // R8 largest count
    unlock(); wr(11'h340, 16'h0025); wr(11'h340, 16'h0007);
    for (int k = 0; k < 8; k++) wr(11'h340 + 11'(k), 16'(k));
    wr(11'h340, 16'h0029);
    idle(40);
    rd(11'h340, v); check("R8 full buffer first", v, 16'h0000);
    rd(11'h347, v); check("R8 full buffer last", v, 16'h0007);

    // R9 abandoned buffer sequences
    unlock(); wr(11'h310, 16'h0025); wr(11'h310, 16'h0008);
    wr(11'h310, 16'h0000); wr(11'h310, 16'h0029);
    idle(30);
    rd(11'h310, v); check("R9 count too large", v, 16'hFFFF);
    unlock(); wr(11'h320, 16'h0025); wr(11'h320, 16'h0001);
    wr(11'h321, 16'h0000); wr(11'h120, 16'h0000); wr(11'h320, 16'h0029);
    idle(30);
    rd(11'h321, v); check("R9 data outside sector", v, 16'hFFFF);
    unlock(); wr(11'h330, 16'h0025); wr(11'h330, 16'h0000);
    wr(11'h330, 16'h0000); wr(11'h330, 16'h0030);
    idle(30);
    rd(11'h330, v); check("R9 wrong commit", v, 16'hFFFF);

    // R11 reset during the first busy cycle
    unlock(); wr(11'h555, 16'h00A0); wr(11'h060, 16'hAAAA);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd(11'h060, v); check("R11 reset ends program", v, 16'hFFFF);
    rd(11'h010, v); check("R11 array kept over reset", v, 16'h1204);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule